// File: doc/BRIEF.md
# Integer Compare and Branch Unit

This block is the execution slice of a small processor that carries out the signed integer relational instructions and the three jump instructions. Each cycle it receives one decoded instruction as a 6-bit opcode, a flag telling whether the second operand comes from an immediate word or from a register, the first register operand, both candidates for the second operand, and the current instruction pointer. It answers in the same cycle with a register write-back value and enable, a taken-branch flag, and the next instruction pointer.

A relational instruction does not touch any flag register. It writes integer 1 or 0 back into its first register, and a following conditional jump tests a register for zero or non-zero. Opcode zero halts the machine. The halt flag is registered, stays set until reset, and freezes the unit once it is set. Every one of the 64 opcode values is legal. Opcodes that belong to other slices pass through with no write and no jump, and only the instruction pointer advances.

Top module: `icb_unit`

## Requirements
- R1: After a synchronous active-low reset, `halted` is 0. While `issue_valid` is 0, `wb_en` and `br_taken` are 0 and `next_ip` equals `cur_ip`.
- R2: For opcodes 0x07 (equal), 0x08 (not equal), 0x09 (greater), 0x0A (greater or equal), 0x0B (less) and 0x0C (less or equal), `wb_en` is 1 and `wb_data` is 1 when `op_a` relates to the second operand that way and 0 otherwise, with both taken as two's-complement signed values of DATA_W bits.
- R3: The second operand is `imm` when `use_imm` is 1 and `op_b_reg` when `use_imm` is 0.
- R4: Opcode 0x02 always sets `br_taken` to 1 and makes `next_ip` the low IP_W bits of the second operand.
- R5: Opcode 0x05 jumps to the second operand exactly when `op_a` is non-zero, and opcode 0x06 jumps exactly when `op_a` is zero. A jump instruction never raises `wb_en`.
- R6: When an issued instruction other than opcode 0x00 takes no jump, `next_ip` is `cur_ip` plus 2 if `use_imm` is 1 and plus 1 if it is 0, modulo 2^IP_W.
- R7: An issued opcode 0x00 gives `wb_en`=0, `br_taken`=0 and `next_ip`=`cur_ip` in its own cycle, and `halted` is 1 from the next clock edge on.
- R8: Once `halted` is 1 it stays 1 until reset. While it is 1, every opcode gives `wb_en`=0, `br_taken`=0 and `next_ip`=`cur_ip`.
- R9: Opcodes outside 0x00, 0x02, 0x05 to 0x0C (for example 0x01, 0x03, 0x3F) give no write-back and no jump, and they only advance the pointer as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 6 | Instruction opcode |
| use_imm | input | 1 | Second operand is the immediate word (instruction is two words long) |
| op_a | input | DATA_W | First register operand (compare source/destination, jump test value) |
| op_b_reg | input | DATA_W | Second register operand |
| imm | input | DATA_W | Immediate word |
| cur_ip | input | IP_W | Current instruction pointer |
| wb_data | output | DATA_W | Value to write into the first register |
| wb_en | output | 1 | Write-back enable |
| br_taken | output | 1 | A jump is taken |
| next_ip | output | IP_W | Instruction pointer for the next instruction |
| halted | output | 1 | Sticky halt flag |

## Verification
The bench builds the unit with DATA_W=16 and IP_W=8. With the 16-bit data width, the signed extremes 0x7FFF and 0x8000 and the value -1 are short constants. That makes it easy to see a sign error in the greater and less relations. With the 8-bit pointer, cur_ip values 0xFE and 0xFF bring the step-by-one and step-by-two wrap within reach, and they also show that a jump target wider than the pointer is truncated to its low bits.

// File: rtl/icb_pkg.sv
// Shared opcode values and decode helpers for the integer compare and
// branch unit. Assumes a 6-bit opcode field in which all 64 values are legal.
package icb_pkg;

    localparam int OPC_W   = 6;
    localparam int NUM_REL = 6;

    typedef logic [OPC_W-1:0] opc_t;

    localparam opc_t OPC_HLT = 6'h00;
    localparam opc_t OPC_JMP = 6'h02;
    localparam opc_t OPC_JT  = 6'h05;
    localparam opc_t OPC_JF  = 6'h06;
    localparam opc_t OPC_IEQ = 6'h07;  // first relational opcode
    localparam opc_t OPC_ILE = 6'h0C;  // last relational opcode

    // True for the six contiguous relational opcodes.
    function automatic logic is_rel(opc_t op);
        return (op >= OPC_IEQ) && (op <= OPC_ILE);
    endfunction

endpackage

// File: rtl/icb_relcmp.sv
// Signed relational evaluator. Computes all six relations of a against b
// in parallel and picks the one that the opcode names. Assumes the relational
// opcodes are contiguous, in the order eq, ne, gt, ge, lt, le. The output is
// 0 for any other opcode.
module icb_relcmp
    import icb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  opc_t              opcode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              holds
);

    logic signed [DATA_W-1:0] a_s;
    logic signed [DATA_W-1:0] b_s;
    logic [NUM_REL-1:0]       rel_vec;
    logic [NUM_REL-1:0]       rel_sel;

    assign a_s = $signed(a);
    assign b_s = $signed(b);

    // Evaluate every relation on the signed operands.
    always_comb begin
        rel_vec[0] = (a_s == b_s);
        rel_vec[1] = (a_s != b_s);
        rel_vec[2] = (a_s >  b_s);
        rel_vec[3] = (a_s >= b_s);
        rel_vec[4] = (a_s <  b_s);
        rel_vec[5] = (a_s <= b_s);
    end

    // One-hot select line for each relational opcode.
    for (genvar g = 0; g < NUM_REL; g++) begin : g_sel
        assign rel_sel[g] = (opcode == opc_t'(OPC_IEQ + g));
    end

    assign holds = |(rel_sel & rel_vec);

endmodule

// File: rtl/icb_branch.sv
// Jump decision. It decides whether the opcode jumps, based on the tested
// register, and it sizes the jump target to the pointer width. Assumes the
// target is the second operand. A wider operand is truncated and a narrower
// one is zero-extended.
module icb_branch
    import icb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IP_W   = 32
) (
    input  opc_t              opcode,
    input  logic [DATA_W-1:0] test_val,
    input  logic [DATA_W-1:0] target_val,
    output logic              take,
    output logic [IP_W-1:0]   target_ip
);

    logic test_nz;

    assign test_nz = |test_val;

    // Jump condition for each jump opcode.
    always_comb begin
        unique case (opcode)
            OPC_JMP: take = 1'b1;
            OPC_JT:  take = test_nz;
            OPC_JF:  take = !test_nz;
            default: take = 1'b0;
        endcase
    end

    // Fit the target to the pointer width.
    if (IP_W <= DATA_W) begin : g_trunc
        assign target_ip = target_val[IP_W-1:0];
    end else begin : g_zext
        assign target_ip = {{(IP_W-DATA_W){1'b0}}, target_val};
    end

endmodule

// File: rtl/icb_ipnext.sv
// Next instruction pointer. The pointer holds, jumps to the target, or
// steps past the current instruction, which is one word long or two words
// when an immediate follows. Assumes wrap-around modulo 2^IP_W.
module icb_ipnext #(
    parameter int IP_W = 32
) (
    input  logic [IP_W-1:0] cur_ip,
    input  logic            use_imm,
    input  logic            hold,
    input  logic            take,
    input  logic [IP_W-1:0] target_ip,
    output logic [IP_W-1:0] next_ip
);

    localparam logic [IP_W-1:0] STEP_SHORT = IP_W'(1);
    localparam logic [IP_W-1:0] STEP_LONG  = IP_W'(2);

    logic [IP_W-1:0] seq_ip;

    assign seq_ip = cur_ip + (use_imm ? STEP_LONG : STEP_SHORT);

    // Priority: hold, then jump, then sequential step.
    always_comb begin
        if (hold)      next_ip = cur_ip;
        else if (take) next_ip = target_ip;
        else           next_ip = seq_ip;
    end

endmodule

// File: rtl/icb_unit.sv
// Integer compare and branch unit (top). It picks the second operand, runs
// the relational evaluator and the jump decision, forms the next pointer,
// and keeps a sticky halt flag that opcode 0 sets. Assumes one decoded
// instruction per cycle, qualified by issue_valid. A synchronous active-low
// reset clears the halt flag.
module icb_unit
    import icb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IP_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [5:0]        opcode,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b_reg,
    input  logic [DATA_W-1:0] imm,
    input  logic [IP_W-1:0]   cur_ip,
    output logic [DATA_W-1:0] wb_data,
    output logic              wb_en,
    output logic              br_taken,
    output logic [IP_W-1:0]   next_ip,
    output logic              halted
);

    logic [DATA_W-1:0] op_b;
    logic              rel_holds;
    logic              raw_take;
    logic [IP_W-1:0]   target_ip;
    logic              active;
    logic              is_halt;
    logic              halted_q;

    assign op_b    = use_imm ? imm : op_b_reg;
    assign active  = issue_valid && !halted_q;
    assign is_halt = (opcode == OPC_HLT);

    icb_relcmp #(.DATA_W(DATA_W)) i_relcmp (
        .opcode (opcode),
        .a      (op_a),
        .b      (op_b),
        .holds  (rel_holds)
    );

    icb_branch #(.DATA_W(DATA_W), .IP_W(IP_W)) i_branch (
        .opcode     (opcode),
        .test_val   (op_a),
        .target_val (op_b),
        .take       (raw_take),
        .target_ip  (target_ip)
    );

    icb_ipnext #(.IP_W(IP_W)) i_ipnext (
        .cur_ip    (cur_ip),
        .use_imm   (use_imm),
        .hold      (!active || is_halt),
        .take      (br_taken),
        .target_ip (target_ip),
        .next_ip   (next_ip)
    );

    // Write-back: boolean result of a relational opcode into the first register.
    always_comb begin
        wb_data = {{(DATA_W-1){1'b0}}, rel_holds};
        wb_en   = active && is_rel(opcode);
    end

    assign br_taken = active && raw_take;

    // Sticky halt flag, set by an issued opcode 0 and cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                     halted_q <= 1'b0;
        else if (issue_valid && is_halt) halted_q <= 1'b1;
    end

    assign halted = halted_q;

    // R8: once halted, stays halted.
    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R8: a halted unit neither writes nor jumps.
    assert_halted_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!wb_en && !br_taken && next_ip == cur_ip));

    // R7: an issued halt opcode sets the flag at the next edge.
    assert_halt_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && opcode == OPC_HLT) |=> halted);

    // R5: a jump never writes back.
    assert_no_wb_on_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_en && br_taken));

    // R4: a taken jump lands on the operand target.
    assert_jump_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (next_ip == IP_W'(op_b)));

    // R1: with nothing issued the unit is idle.
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (!wb_en && !br_taken && next_ip == cur_ip));

endmodule

// File: tb/test_icb_unit.sv
module test_icb_unit;

    localparam int DW = 16;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          issue_valid;
    logic [5:0]    opcode;
    logic          use_imm;
    logic [DW-1:0] op_a, op_b_reg, imm;
    logic [IW-1:0] cur_ip;
    logic [DW-1:0] wb_data;
    logic          wb_en, br_taken, halted;
    logic [IW-1:0] next_ip;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    icb_unit #(.DATA_W(DW), .IP_W(IW)) i_icb_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
        .use_imm(use_imm), .op_a(op_a), .op_b_reg(op_b_reg), .imm(imm),
        .cur_ip(cur_ip), .wb_data(wb_data), .wb_en(wb_en), .br_taken(br_taken),
        .next_ip(next_ip), .halted(halted)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one instruction at the falling edge and let outputs settle.
    task automatic apply(input logic v, input logic [5:0] op, input logic ui,
                         input logic [DW-1:0] a, input logic [DW-1:0] br,
                         input logic [DW-1:0] im, input logic [IW-1:0] ip);
        @(negedge clk);
        issue_valid = v; opcode = op; use_imm = ui;
        op_a = a; op_b_reg = br; imm = im; cur_ip = ip;
        #2;
    endtask

    function automatic logic exp_rel(input logic [5:0] op,
                                     input logic signed [DW-1:0] a,
                                     input logic signed [DW-1:0] b);
        case (op)
            6'h07: return a == b;
            6'h08: return a != b;
            6'h09: return a >  b;
            6'h0A: return a >= b;
            6'h0B: return a <  b;
            default: return a <= b;
        endcase
    endfunction

    task automatic t_reset();
        apply(1'b0, 6'h02, 1'b1, 16'h0001, 16'h0000, 16'h0033, 8'h10);
        chk("R1 halted after reset", halted, 0);
        chk("R1 idle wb_en", wb_en, 0);
        chk("R1 idle br_taken", br_taken, 0);
        chk("R1 idle next_ip", next_ip, 8'h10);
    endtask

    task automatic t_compares();
        logic [DW-1:0] pa [6] = '{16'h0005, 16'h0003, 16'h0009, 16'h8000, 16'hFFFF, 16'h7FFF};
        logic [DW-1:0] pb [6] = '{16'h0005, 16'h0009, 16'h0003, 16'h7FFF, 16'h0001, 16'h8000};
        for (int op = 7; op <= 12; op++) begin
            for (int k = 0; k < 6; k++) begin
                logic ui;
                logic e;
                ui = (k + op) % 2 == 1;
                e = exp_rel(6'(op), pa[k], pb[k]);
                if (ui) apply(1'b1, 6'(op), 1'b1, pa[k], ~pb[k], pb[k], 8'h20);
                else    apply(1'b1, 6'(op), 1'b0, pa[k], pb[k], ~pb[k], 8'h20);
                chk("R2 compare wb_en", wb_en, 1);
                chk(ui ? "R2 R3 compare result, imm operand" : "R2 R3 compare result, reg operand",
                    wb_data, {31'b0, e});
                chk("R5 compare no jump", br_taken, 0);
                chk("R6 compare advance", next_ip, ui ? 8'h22 : 8'h21);
            end
        end
    endtask

    task automatic t_jumps();
        apply(1'b1, 6'h02, 1'b1, 16'h0000, 16'h0077, 16'h1234, 8'h50);
        chk("R4 JMP imm taken", br_taken, 1);
        chk("R4 JMP imm target", next_ip, 8'h34);
        chk("R5 JMP no wb", wb_en, 0);
        apply(1'b1, 6'h02, 1'b0, 16'h0000, 16'h0077, 16'h1234, 8'h50);
        chk("R3 R4 JMP reg target", next_ip, 8'h77);
        apply(1'b1, 6'h05, 1'b1, 16'h0000, 16'h0000, 16'h0090, 8'h60);
        chk("R5 JT zero not taken", br_taken, 0);
        chk("R6 JT fallthrough", next_ip, 8'h62);
        apply(1'b1, 6'h05, 1'b0, 16'h8000, 16'h00A0, 16'h0090, 8'h60);
        chk("R5 JT nonzero taken", br_taken, 1);
        chk("R5 JT target", next_ip, 8'hA0);
        apply(1'b1, 6'h06, 1'b1, 16'h0000, 16'h0000, 16'h00C4, 8'h60);
        chk("R5 JF zero taken", next_ip, 8'hC4);
        chk("R5 JF no wb", wb_en, 0);
        apply(1'b1, 6'h06, 1'b0, 16'h0001, 16'h00C4, 16'h0000, 8'h60);
        chk("R5 JF nonzero not taken", br_taken, 0);
        chk("R6 JF fallthrough", next_ip, 8'h61);
    endtask

    task automatic t_other_ops();
        logic [5:0] ops [3] = '{6'h01, 6'h03, 6'h3F};
        foreach (ops[i]) begin
            apply(1'b1, ops[i], 1'b1, 16'h0000, 16'h0011, 16'h0022, 8'hFF);
            chk("R9 other op no wb", wb_en, 0);
            chk("R9 other op no jump", br_taken, 0);
            chk("R6 R9 wrap by two", next_ip, 8'h01);
            apply(1'b1, ops[i], 1'b0, 16'h0000, 16'h0011, 16'h0022, 8'hFF);
            chk("R6 R9 wrap by one", next_ip, 8'h00);
        end
        apply(1'b1, 6'h09, 1'b1, 16'h0004, 16'h0000, 16'h0003, 8'hFE);
        chk("R6 compare wrap", next_ip, 8'h00);
    endtask

    task automatic t_halt();
        apply(1'b0, 6'h00, 1'b0, 16'h0, 16'h0, 16'h0, 8'h40);
        apply(1'b0, 6'h07, 1'b0, 16'h0, 16'h0, 16'h0, 8'h40);
        chk("R7 unissued opcode 0 does not halt", halted, 0);
        apply(1'b1, 6'h00, 1'b1, 16'h0001, 16'h0002, 16'h0003, 8'h40);
        chk("R7 halt next_ip holds", next_ip, 8'h40);
        chk("R7 halt no wb", wb_en, 0);
        chk("R7 halt no jump", br_taken, 0);
        apply(1'b1, 6'h07, 1'b0, 16'h0005, 16'h0005, 16'h0000, 8'h41);
        chk("R7 halted after edge", halted, 1);
        chk("R8 halted compare no wb", wb_en, 0);
        chk("R8 halted next_ip holds", next_ip, 8'h41);
        apply(1'b1, 6'h02, 1'b1, 16'h0000, 16'h0000, 16'h0099, 8'h41);
        chk("R8 halted JMP not taken", br_taken, 0);
        chk("R8 halted JMP next_ip", next_ip, 8'h41);
        for (int c = 0; c < 5; c++) apply(1'b0, 6'h07, 1'b0, 16'h0, 16'h0, 16'h0, 8'h41);
        chk("R8 halt sticky", halted, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #2;
        chk("R1 reset clears halt", halted, 0);
        apply(1'b1, 6'h08, 1'b0, 16'h0005, 16'h0006, 16'h0000, 8'h10);
        chk("R2 works after reset", wb_data, 1);
    endtask

    initial begin
        rst_n = 1'b0; issue_valid = 1'b0; opcode = '0; use_imm = 1'b0;
        op_a = '0; op_b_reg = '0; imm = '0; cur_ip = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_compares();
        t_jumps();
        t_other_ops();
        t_halt();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule